// File: doc/BRIEF.md
# Reshapeable Two-Port Memory

This block is a memory with one write-only port and one read-only port, each on its own clock. Behind the ports sits one fixed array of 1,152 bits. A two-bit shape input sets how that array is seen: as 64 words of 18 bits, 128 of 9, 256 of 4 or 512 of 2. Both ports use the same 9-bit address bus and the same 18-bit data width. In the narrower shapes, only the low address bits and the low data bits are used.

The array is kept as 64 rows of 18 bits. In a narrow shape, the low six address bits pick the row and the address bits above them pick a lane inside that row. Every shape therefore addresses the same physical bits. Changing the shape reinterprets the stored contents and does not erase them.

The read port works in one of two ways. It can register the word on its clock, gated by an enable. It can also pass the addressed word straight through with no clock, which a separate select input chooses.

Top module: `aspect_dpram`

## Requirements
- R1: The shape input is decoded as 00 = 64x18, 01 = 128x9, 10 = 256x4 and 11 = 512x2. A word of width W occupies data bits W-1:0 of both data buses.
- R2: The row is address bits 5:0. The lane is address bit 6 for 128x9, bits 7:6 for 256x4 and bits 8:6 for 512x2; 64x18 has no lane. Lane k covers row bits k*W+W-1 down to k*W. Address bits above the ones a shape uses are ignored.
- R3: A write takes effect on the rising write-clock edge while wr_en is 1 and changes only the addressed lane. When wr_en is 0 the array does not change.
- R4: Write-data bits above the current word width are ignored.
- R5: Read-data bits above the current word width read as zero.
- R6: With async_rd = 0, rd_data loads the addressed word on a rising read-clock edge when rd_en is 1. It holds its value when rd_en is 0.
- R7: In registered mode, a read at the same edge as a write to the same word returns the earlier contents. The next enabled read edge returns the new contents.
- R8: With async_rd = 1, rd_data follows rd_addr, shape and the array contents without waiting for a read-clock edge. A completed write is visible at once.
- R9: rst_n low clears the read register to zero at once. Its release is synchronised to the read clock. The array contents survive a reset.
- R10: Changing the shape leaves the array contents unchanged. Data written in one shape reads back in another shape according to R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-port clock |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 9 | Write word address |
| wr_data | input | 18 | Write data, low bits used in narrow shapes |
| rd_clk | input | 1 | Read-port clock |
| rst_n | input | 1 | Asynchronous active-low reset of the read register |
| rd_en | input | 1 | Read enable for registered reads |
| rd_addr | input | 9 | Read word address |
| async_rd | input | 1 | 1 = unclocked read path, 0 = registered read |
| shape | input | 2 | Aspect-ratio select |
| rd_data | output | 18 | Read data |

## Verification
The checker assumes that the read-side controls and the shape change only away from the clock edges at which it samples. It also assumes that the unclocked read path is judged only while both the shape and the read address hold steady across a write-clock period with no write in it. The bench keeps to this: it drives every input on the falling edge of a single shared clock and samples outputs there too. The bench initialises each row before reading it, so that no comparison involves an unwritten bit.

// File: rtl/aspect_dpram_pkg.sv
package aspect_dpram_pkg;
  localparam int unsigned ROW_W       = 18;
  localparam int unsigned ROWS        = 64;
  localparam int unsigned ADDR_W      = 9;
  localparam int unsigned ROW_AW      = $clog2(ROWS);
  localparam int unsigned LANE_AW     = ADDR_W - ROW_AW;
  localparam int unsigned SHIFT_W     = $clog2(ROW_W);
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    SHAPE_W18 = 2'b00,
    SHAPE_W9  = 2'b01,
    SHAPE_W4  = 2'b10,
    SHAPE_W2  = 2'b11
  } shape_e;

  function automatic logic [SHIFT_W-1:0] lane_width(input shape_e s);
    case (s)
      SHAPE_W18: lane_width = SHIFT_W'(18);
      SHAPE_W9:  lane_width = SHIFT_W'(9);
      SHAPE_W4:  lane_width = SHIFT_W'(4);
      default:   lane_width = SHIFT_W'(2);
    endcase
  endfunction

  function automatic logic [LANE_AW-1:0] lane_keep(input shape_e s);
    case (s)
      SHAPE_W18: lane_keep = LANE_AW'(0);
      SHAPE_W9:  lane_keep = LANE_AW'(1);
      SHAPE_W4:  lane_keep = LANE_AW'(3);
      default:   lane_keep = LANE_AW'(7);
    endcase
  endfunction
endpackage

// File: rtl/aspect_lane_map.sv
module aspect_lane_map
  import aspect_dpram_pkg::*;
(
  input  shape_e              shape,
  input  logic [ADDR_W-1:0]   addr,
  output logic [ROW_AW-1:0]   row,
  output logic [SHIFT_W-1:0]  shamt,
  output logic [ROW_W-1:0]    low_mask
);
  logic [LANE_AW-1:0] lane_sel;
  logic [SHIFT_W-1:0] width;

  always_comb begin
    width    = lane_width(shape);
    lane_sel = addr[ADDR_W-1:ROW_AW] & lane_keep(shape);
    row      = addr[ROW_AW-1:0];
    shamt    = SHIFT_W'(lane_sel) * width;
    low_mask = (ROW_W'(1) << width) - ROW_W'(1);
  end
endmodule

// File: rtl/aspect_store.sv
module aspect_store
  import aspect_dpram_pkg::*;
(
  input  logic                wr_clk,
  input  logic                wr_en,
  input  logic [ROW_AW-1:0]   wr_row,
  input  logic [ROW_W-1:0]    wr_mask,
  input  logic [ROW_W-1:0]    wr_bits,
  input  logic [ROW_AW-1:0]   rd_row,
  output logic [ROW_W-1:0]    rd_word
);
  logic [ROW_W-1:0] mem [ROWS];
  logic [ROW_W-1:0] row_nxt;

  always_comb begin
    row_nxt = (mem[wr_row] & ~wr_mask) | (wr_bits & wr_mask);
  end

  always_ff @(posedge wr_clk) begin
    if (wr_en) begin
      mem[wr_row] <= row_nxt;
    end
  end

  assign rd_word = mem[rd_row];
endmodule

// File: rtl/aspect_rd_port.sv
module aspect_rd_port
  import aspect_dpram_pkg::*;
(
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              async_rd,
  input  logic [ROW_W-1:0]  fetched,
  output logic [ROW_W-1:0]  rd_data
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rst_q_n;
  logic [ROW_W-1:0]       rd_q;
  logic [ROW_W-1:0]       rd_q_nxt;

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_q_n = sync_q[SYNC_STAGES-1];

  always_comb begin
    rd_q_nxt = rd_en ? fetched : rd_q;
  end

  always_ff @(posedge rd_clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_q_nxt;
    end
  end

  assign rd_data = async_rd ? fetched : rd_q;
endmodule

// File: rtl/aspect_dpram.sv
module aspect_dpram
  import aspect_dpram_pkg::*;
(
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ROW_W-1:0]  wr_data,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              async_rd,
  input  logic [1:0]        shape,
  output logic [ROW_W-1:0]  rd_data
);
  shape_e             shape_sel;
  logic [ROW_AW-1:0]  w_row, r_row;
  logic [SHIFT_W-1:0] w_shamt, r_shamt;
  logic [ROW_W-1:0]   w_low, r_low;
  logic [ROW_W-1:0]   w_mask, w_bits;
  logic [ROW_W-1:0]   rd_word, fetched;

  assign shape_sel = shape_e'(shape);

  aspect_lane_map u_wmap (
    .shape    (shape_sel),
    .addr     (wr_addr),
    .row      (w_row),
    .shamt    (w_shamt),
    .low_mask (w_low)
  );

  aspect_lane_map u_rmap (
    .shape    (shape_sel),
    .addr     (rd_addr),
    .row      (r_row),
    .shamt    (r_shamt),
    .low_mask (r_low)
  );

  always_comb begin
    w_mask  = w_low << w_shamt;
    w_bits  = (wr_data & w_low) << w_shamt;
    fetched = (rd_word >> r_shamt) & r_low;
  end

  aspect_store u_store (
    .wr_clk  (wr_clk),
    .wr_en   (wr_en),
    .wr_row  (w_row),
    .wr_mask (w_mask),
    .wr_bits (w_bits),
    .rd_row  (r_row),
    .rd_word (rd_word)
  );

  aspect_rd_port u_rport (
    .rd_clk   (rd_clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .async_rd (async_rd),
    .fetched  (fetched),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/aspect_dpram_chk.sv
module aspect_dpram_chk
  import aspect_dpram_pkg::*;
(
  input logic              wr_clk,
  input logic              wr_en,
  input logic              rd_clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              async_rd,
  input logic [1:0]        shape,
  input logic [ROW_W-1:0]  rd_data
);
  logic [ROW_W-1:0] legal_bits;

  always_comb begin
    case (shape)
      2'b00:   legal_bits = {ROW_W{1'b1}};
      2'b01:   legal_bits = ROW_W'(18'h001FF);
      2'b10:   legal_bits = ROW_W'(18'h0000F);
      default: legal_bits = ROW_W'(18'h00003);
    endcase
  end

  // R5: no bit above the word width is ever set on the unclocked path
  assert_upper_zero_R5: assert property (@(posedge rd_clk) disable iff (!rst_n)
    async_rd |-> ((rd_data & ~legal_bits) == '0));

  // R6: registered read holds while disabled
  assert_hold_R6: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!rd_en && !async_rd) |=> (async_rd || $stable(rd_data)));

  // R8: with no write, steady address and shape keep the unclocked output steady
  assert_async_steady_R8: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (async_rd && $past(async_rd) && !$past(wr_en) && $stable(rd_addr) && $stable(shape))
      |-> $stable(rd_data));

  // R9: while reset is low the registered output reads zero
  assert_reset_clear_R9: assert property (@(posedge rd_clk)
    (!rst_n && !async_rd) |-> (rd_data == '0));
endmodule

bind aspect_dpram aspect_dpram_chk u_chk (
  .wr_clk   (wr_clk),
  .wr_en    (wr_en),
  .rd_clk   (rd_clk),
  .rst_n    (rst_n),
  .rd_en    (rd_en),
  .rd_addr  (rd_addr),
  .async_rd (async_rd),
  .shape    (shape),
  .rd_data  (rd_data)
);

// File: tb/aspect_dpram_tb.sv
module aspect_dpram_tb;
  logic        clk;
  logic        wr_en, rst_n, rd_en, async_rd;
  logic [8:0]  wr_addr, rd_addr;
  logic [17:0] wr_data;
  logic [1:0]  shape;
  logic [17:0] rd_data;
  int checks;
  int fails;
  bit done;

  // fields: shape[56:55] we[54] waddr[53:45] wdata[44:27] raddr[26:18] expected[17:0]
  localparam int NVEC = 19;
  localparam logic [56:0] VEC [NVEC] = '{
    {2'd0, 1'b1, 9'd3,   18'h2A5A5, 9'd3,   18'h2A5A5},
    {2'd1, 1'b0, 9'd0,   18'h00000, 9'd3,   18'h001A5},
    {2'd1, 1'b0, 9'd0,   18'h00000, 9'd67,  18'h00152},
    {2'd2, 1'b0, 9'd0,   18'h00000, 9'd3,   18'h00005},
    {2'd2, 1'b0, 9'd0,   18'h00000, 9'd67,  18'h0000A},
    {2'd2, 1'b0, 9'd0,   18'h00000, 9'd131, 18'h00005},
    {2'd2, 1'b0, 9'd0,   18'h00000, 9'd195, 18'h0000A},
    {2'd3, 1'b0, 9'd0,   18'h00000, 9'd451, 18'h00002},
    {2'd3, 1'b0, 9'd0,   18'h00000, 9'd3,   18'h00001},
    {2'd0, 1'b1, 9'd10,  18'h00000, 9'd10,  18'h00000},
    {2'd1, 1'b1, 9'd74,  18'h3FF55, 9'd74,  18'h00155},
    {2'd0, 1'b0, 9'd0,   18'h00000, 9'd10,  18'h2AA00},
    {2'd3, 1'b1, 9'd138, 18'h00003, 9'd138, 18'h00003},
    {2'd0, 1'b0, 9'd0,   18'h00000, 9'd10,  18'h2AA30},
    {2'd0, 1'b1, 9'd202, 18'h12345, 9'd10,  18'h12345},
    {2'd0, 1'b0, 9'd0,   18'h00000, 9'd458, 18'h12345},
    {2'd2, 1'b1, 9'd330, 18'h0000F, 9'd74,  18'h0000F},
    {2'd0, 1'b0, 9'd0,   18'h00000, 9'd10,  18'h123F5},
    {2'd0, 1'b0, 9'd10,  18'h3FFFF, 9'd10,  18'h123F5}
  };

  aspect_dpram u_dut (
    .wr_clk   (clk),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_clk   (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .async_rd (async_rd),
    .shape    (shape),
    .rd_data  (rd_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; async_rd = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0; shape = 2'b00;
    repeat (3) @(negedge clk);
    check("R9 reset value", rd_data, 18'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // table walk: R1 R2 R3 R4 R5 R8 R10
    for (int i = 0; i < NVEC; i++) begin
      shape    = VEC[i][56:55];
      wr_en    = VEC[i][54];
      wr_addr  = VEC[i][53:45];
      wr_data  = VEC[i][44:27];
      rd_addr  = VEC[i][26:18];
      async_rd = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      check($sformatf("R1 R2 R3 R4 R5 R8 R10 vector %0d", i), rd_data, VEC[i][17:0]);
    end

    // R6: registered load then hold
    shape = 2'b00; async_rd = 1'b0; rd_en = 1'b1; rd_addr = 9'd10;
    @(negedge clk);
    check("R6 registered load", rd_data, 18'h123F5);
    rd_en = 1'b0; rd_addr = 9'd3;
    @(negedge clk);
    check("R6 hold while disabled", rd_data, 18'h123F5);
    async_rd = 1'b1;
    #1;
    check("R8 unclocked follows address", rd_data, 18'h2A5A5);

    // R7: same-edge write and read
    @(negedge clk);
    async_rd = 1'b0; rd_en = 1'b1; rd_addr = 9'd3;
    wr_en = 1'b1; wr_addr = 9'd3; wr_data = 18'h00011;
    @(negedge clk);
    wr_en = 1'b0;
    check("R7 old contents on colliding edge", rd_data, 18'h2A5A5);
    @(negedge clk);
    check("R7 new contents next edge", rd_data, 18'h00011);

    // R5 on the registered path
    shape = 2'b01; wr_en = 1'b1; wr_addr = 9'd3; wr_data = 18'h3FFFF;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    check("R5 registered upper bits zero", rd_data, 18'h001FF);

    // R9: asynchronous clear, held after release, memory kept
    rst_n = 1'b0;
    #1;
    check("R9 immediate clear", rd_data, 18'h0);
    rd_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 stays clear after release", rd_data, 18'h0);
    shape = 2'b00; async_rd = 1'b1; rd_addr = 9'd10;
    #1;
    check("R9 array survives reset", rd_data, 18'h123F5);
    @(negedge clk);
    finish_run();
  end
endmodule